// File: doc/BRIEF.md
# Maskable BCD Alarm Comparator

This block watches a running calendar that counts in BCD and compares it with a programmed alarm word. It makes the comparison once per calendar tick. When every field that is not masked equals the current calendar value, it latches an alarm flag and sends out a one-cycle event pulse. An interrupt line follows the flag, gated by an interrupt enable. The day part of the alarm can hold either a date of the month or a day of the week. Each of the four fields (seconds, minutes, hours, day) has its own don't-care bit, so a single word can describe a one-shot, daily, hourly or per-minute alarm.

The alarm word is guarded by a disable handshake. Clearing the alarm enable starts a short wait, and only when the wait ends does a write-allowed flag rise. Alarm word writes that arrive while that flag is low are dropped. Setting the enable again lowers the flag at once. Software acknowledges an alarm by pulsing the clear input. While the flag stays set, a further match does not produce another event pulse.

Top module: `bcd_alarm_unit`

## Requirements
- R1: After a synchronous reset the alarm flag, event pulse, interrupt and alarm enable are 0, the stored alarm word is all zeros, and the write-allowed flag is 1.
- R2: The write-allowed flag falls at the clock edge on which a configuration write sets the alarm enable. It rises exactly WAIT_CYC clock edges after the edge on which a configuration write clears the enable.
- R3: An alarm word write is stored only while the write-allowed flag is 1. Otherwise the word read back on `alarm_word` does not change.
- R4: The alarm word has these fields. Bits 6:0 hold BCD seconds, with their ignore bit at 7. Bits 14:8 hold BCD minutes, with their ignore bit at 15. Bits 21:16 hold BCD hours and bit 22 the PM flag, with the hour ignore bit at 23. When a tick arrives with the enable at 1 and all unignored fields equal the calendar (hours equal only if hour and PM both match), the flag and the event pulse are 1 after that edge.
- R5: A field whose ignore bit is 1 takes no part in the comparison. With only the seconds unignored, the alarm matches once per minute.
- R6: Bit 31 ignores the day field. When bit 30 is 1, bits 27:24 are compared with the weekday (1 to 7). When bit 30 is 0, bits 29:24 are compared with the BCD date.
- R7: No match is taken in a cycle without a tick, or while the alarm enable is 0.
- R8: The flag stays 1 until `flag_clr` is pulsed. A match while the flag is already set gives no event pulse.
- R9: `irq` is 1 exactly when the flag is 1 and the interrupt enable is 1.
- R10: When a match and a clear fall in the same cycle, the flag ends up set and an event pulse is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_tick | input | 1 | One-cycle calendar advance strobe |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hours, BCD |
| cur_pm | input | 1 | Current PM indicator |
| cur_date | input | 6 | Current date of month, BCD |
| cur_wday | input | 3 | Current weekday, 1 to 7 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_alm_en | input | 1 | Alarm enable value written by cfg_we |
| cfg_irq_en | input | 1 | Interrupt enable value written by cfg_we |
| aw_we | input | 1 | Alarm word write strobe |
| aw_data | input | 32 | Alarm word write data |
| flag_clr | input | 1 | Pulse that clears the alarm flag |
| alarm_word | output | 32 | Stored alarm word |
| alm_en | output | 1 | Current alarm enable |
| wr_ok | output | 1 | Alarm word write allowed |
| alarm_flag | output | 1 | Latched alarm flag |
| alarm_evt | output | 1 | One-cycle alarm event pulse |
| irq | output | 1 | Alarm interrupt |

## Verification
The hardest situation to reach from the ports is a second match landing while the flag is still set, first alone and then in the same cycle as a clear. Only a tick whose calendar values satisfy the stored word can produce it. The stimulus programs a word through the full disable/wait/write/enable handshake, takes one match and leaves it unacknowledged. It then repeats the matching calendar values with and without `flag_clr`. The sweeps over seconds, hours with PM, dates and weekdays compare every tick against an expected match computed from the field layout.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;

    localparam int WORD_W = 32;

    // Alarm word layout; bit positions are decoded by software
    typedef struct packed {
        logic       day_ign;   // 31
        logic       by_wday;   // 30
        logic [5:0] day;       // 29:24
        logic       hr_ign;    // 23
        logic       pm;        // 22
        logic [5:0] hr;        // 21:16
        logic       mn_ign;    // 15
        logic [6:0] mn;        // 14:8
        logic       sc_ign;    // 7
        logic [6:0] sc;        // 6:0
    } alm_word_t;

    typedef struct packed {
        logic [6:0] sc;
        logic [6:0] mn;
        logic [5:0] hr;
        logic       pm;
        logic [5:0] date;
        logic [2:0] wday;
    } cal_now_t;

    typedef struct packed {
        logic sc;
        logic mn;
        logic hr;
        logic day;
    } field_hit_t;

    function automatic logic field_ok(input logic ign, input logic eq);
        return ign | eq;
    endfunction

endpackage

// File: rtl/alarm_wr_gate.sv
module alarm_wr_gate
    import bcd_alarm_pkg::*;
#(
    parameter int WAIT_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_alm_en,
    input  logic              aw_we,
    input  logic [WORD_W-1:0] aw_data,
    output logic              en,
    output logic              ok,
    output alm_word_t         word
);
    localparam int CNT_W = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYC - 1);

    logic             en_q;
    logic             ok_q;
    logic [CNT_W-1:0] cnt_q;
    alm_word_t        word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            ok_q   <= 1'b1;
            cnt_q  <= '0;
            word_q <= '0;
        end else begin
            if (cfg_we) en_q <= cfg_alm_en;
            if (aw_we && ok_q) word_q <= alm_word_t'(aw_data);
            if (cfg_we && cfg_alm_en) begin
                ok_q  <= 1'b0;
                cnt_q <= '0;
            end else if (!en_q && !ok_q) begin
                if (cnt_q == CNT_LAST) begin
                    ok_q  <= 1'b1;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign en   = en_q;
    assign ok   = ok_q;
    assign word = word_q;

endmodule

// File: rtl/alarm_match.sv
module alarm_match
    import bcd_alarm_pkg::*;
(
    input  alm_word_t  word,
    input  cal_now_t   now,
    output field_hit_t hits,
    output logic       all_hit
);
    logic day_eq;

    always_comb begin
        if (word.by_wday) day_eq = (word.day[3:0] == {1'b0, now.wday});
        else              day_eq = (word.day == now.date);

        hits.sc  = field_ok(word.sc_ign,  word.sc == now.sc);
        hits.mn  = field_ok(word.mn_ign,  word.mn == now.mn);
        hits.hr  = field_ok(word.hr_ign,  (word.hr == now.hr) && (word.pm == now.pm));
        hits.day = field_ok(word.day_ign, day_eq);
        all_hit  = &hits;
    end

endmodule

// File: rtl/alarm_flag_ctl.sv
module alarm_flag_ctl (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic en,
    input  logic match,
    input  logic clr,
    output logic flag,
    output logic evt
);
    logic flag_q;
    logic evt_q;
    logic hit;

    assign hit = tick & en & match;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            evt_q  <= 1'b0;
        end else begin
            flag_q <= (flag_q & ~clr) | hit;
            evt_q  <= hit & (~flag_q | clr);
        end
    end

    assign flag = flag_q;
    assign evt  = evt_q;

endmodule

// File: rtl/bcd_alarm_unit.sv
module bcd_alarm_unit
    import bcd_alarm_pkg::*;
#(
    parameter int WAIT_CYC = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cal_tick,
    input  logic [6:0]  cur_sec,
    input  logic [6:0]  cur_min,
    input  logic [5:0]  cur_hour,
    input  logic        cur_pm,
    input  logic [5:0]  cur_date,
    input  logic [2:0]  cur_wday,
    input  logic        cfg_we,
    input  logic        cfg_alm_en,
    input  logic        cfg_irq_en,
    input  logic        aw_we,
    input  logic [31:0] aw_data,
    input  logic        flag_clr,
    output logic [31:0] alarm_word,
    output logic        alm_en,
    output logic        wr_ok,
    output logic        alarm_flag,
    output logic        alarm_evt,
    output logic        irq
);
    alm_word_t  word;
    cal_now_t   now;
    field_hit_t hits;
    logic       all_hit;
    logic       irq_en_q;

    assign now = '{sc: cur_sec, mn: cur_min, hr: cur_hour, pm: cur_pm,
                   date: cur_date, wday: cur_wday};

    alarm_wr_gate #(.WAIT_CYC(WAIT_CYC)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_alm_en(cfg_alm_en),
        .aw_we     (aw_we),
        .aw_data   (aw_data),
        .en        (alm_en),
        .ok        (wr_ok),
        .word      (word)
    );

    alarm_match u_match (
        .word   (word),
        .now    (now),
        .hits   (hits),
        .all_hit(all_hit)
    );

    alarm_flag_ctl u_flag (
        .clk  (clk),
        .rst  (rst),
        .tick (cal_tick),
        .en   (alm_en),
        .match(all_hit),
        .clr  (flag_clr),
        .flag (alarm_flag),
        .evt  (alarm_evt)
    );

    always_ff @(posedge clk) begin
        if (rst)         irq_en_q <= 1'b0;
        else if (cfg_we) irq_en_q <= cfg_irq_en;
    end

    assign alarm_word = word;
    assign irq        = alarm_flag & irq_en_q;

endmodule

// File: rtl/bcd_alarm_chk.sv
module bcd_alarm_chk (
    input logic        clk,
    input logic        rst,
    input logic        cal_tick,
    input logic        cfg_we,
    input logic        cfg_alm_en,
    input logic        flag_clr,
    input logic [31:0] alarm_word,
    input logic        wr_ok,
    input logic        alarm_flag,
    input logic        alarm_evt,
    input logic        irq
);
    // R2
    wr_ok_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_alm_en) |=> !wr_ok);

    // R3
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_ok |=> $stable(alarm_word));

    // R4
    flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_flag) |-> alarm_evt);

    // R7
    no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !cal_tick |=> !alarm_evt);

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (alarm_flag && !flag_clr) |=> alarm_flag);

    // R8
    evt_flag_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_evt |-> alarm_flag);

    // R9
    irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> alarm_flag);

endmodule

bind bcd_alarm_unit bcd_alarm_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cal_tick  (cal_tick),
    .cfg_we    (cfg_we),
    .cfg_alm_en(cfg_alm_en),
    .flag_clr  (flag_clr),
    .alarm_word(alarm_word),
    .wr_ok     (wr_ok),
    .alarm_flag(alarm_flag),
    .alarm_evt (alarm_evt),
    .irq       (irq)
);

// File: tb/bcd_alarm_unit_tb.sv
module bcd_alarm_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cal_tick = 1'b0;
    logic [6:0]  cur_sec = '0;
    logic [6:0]  cur_min = '0;
    logic [5:0]  cur_hour = '0;
    logic        cur_pm = 1'b0;
    logic [5:0]  cur_date = 6'h01;
    logic [2:0]  cur_wday = 3'd1;
    logic        cfg_we = 1'b0;
    logic        cfg_alm_en = 1'b0;
    logic        cfg_irq_en = 1'b0;
    logic        aw_we = 1'b0;
    logic [31:0] aw_data = '0;
    logic        flag_clr = 1'b0;
    logic [31:0] alarm_word;
    logic        alm_en;
    logic        wr_ok;
    logic        alarm_flag;
    logic        alarm_evt;
    logic        irq;

    int nvec = 0;
    int nerr = 0;
    logic [31:0] word_cur = '0;
    logic        en_cur = 1'b0;
    logic        ie_cur = 1'b0;

    always #5 clk = ~clk;

    bcd_alarm_unit #(.WAIT_CYC(2)) u_dut (
        .clk(clk), .rst(rst), .cal_tick(cal_tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_pm(cur_pm),
        .cur_date(cur_date), .cur_wday(cur_wday),
        .cfg_we(cfg_we), .cfg_alm_en(cfg_alm_en), .cfg_irq_en(cfg_irq_en),
        .aw_we(aw_we), .aw_data(aw_data), .flag_clr(flag_clr),
        .alarm_word(alarm_word), .alm_en(alm_en), .wr_ok(wr_ok),
        .alarm_flag(alarm_flag), .alarm_evt(alarm_evt), .irq(irq)
    );

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    // Expected match from the field layout of R4, R5, R6
    function automatic logic exp_hit(input logic [31:0] w, input logic [6:0] s,
                                     input logic [6:0] m, input logic [5:0] h,
                                     input logic p, input logic [5:0] d,
                                     input logic [2:0] wd);
        logic ok_s, ok_m, ok_h, ok_d;
        ok_s = w[7]  || (w[6:0] == s);
        ok_m = w[15] || (w[14:8] == m);
        ok_h = w[23] || ((w[21:16] == h) && (w[22] == p));
        ok_d = w[31] || (w[30] ? (w[27:24] == {1'b0, wd}) : (w[29:24] == d));
        return ok_s && ok_m && ok_h && ok_d;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic en, input logic ie);
        cfg_we = 1'b1; cfg_alm_en = en; cfg_irq_en = ie;
        step();
        cfg_we = 1'b0;
        en_cur = en; ie_cur = ie;
    endtask

    task automatic program_word(input logic [31:0] w, input logic en_after);
        set_cfg(1'b0, ie_cur);
        step();
        step();
        aw_we = 1'b1; aw_data = w;
        step();
        aw_we = 1'b0;
        word_cur = w;
        if (en_after) set_cfg(1'b1, ie_cur);
    endtask

    task automatic apply_vec(input string req, input logic [6:0] s, input logic [6:0] m,
                             input logic [5:0] h, input logic p, input logic [5:0] d,
                             input logic [2:0] wd);
        logic e;
        e = exp_hit(word_cur, s, m, h, p, d, wd) && en_cur;
        cur_sec = s; cur_min = m; cur_hour = h; cur_pm = p; cur_date = d; cur_wday = wd;
        cal_tick = 1'b1;
        step();
        cal_tick = 1'b0;
        chk({req, " flag"}, 32'(alarm_flag), 32'(e));
        chk({req, " evt"},  32'(alarm_evt),  32'(e));
        if (e) begin
            flag_clr = 1'b1;
            step();
            flag_clr = 1'b0;
            chk("R8 clear", 32'(alarm_flag), 32'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        logic [31:0] w;
        step(); step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk("R1 flag", 32'(alarm_flag), 32'd0);
        chk("R1 evt",  32'(alarm_evt),  32'd0);
        chk("R1 irq",  32'(irq),        32'd0);
        chk("R1 en",   32'(alm_en),     32'd0);
        chk("R1 wr_ok", 32'(wr_ok),     32'd1);
        chk("R1 word", alarm_word,      32'd0);

        // R3 write accepted while allowed
        aw_we = 1'b1; aw_data = 32'h0000_1234;
        step();
        aw_we = 1'b0;
        chk("R3 write taken", alarm_word, 32'h0000_1234);

        // R2 fall on enable
        set_cfg(1'b1, 1'b0);
        chk("R2 fall", 32'(wr_ok), 32'd0);
        // R3 write dropped while not allowed
        aw_we = 1'b1; aw_data = 32'hDEAD_BEEF;
        step();
        aw_we = 1'b0;
        chk("R3 write dropped", alarm_word, 32'h0000_1234);

        // R2 rise exactly two edges after disable
        set_cfg(1'b0, 1'b0);
        chk("R2 wait edge0", 32'(wr_ok), 32'd0);
        aw_we = 1'b1; aw_data = 32'hCAFE_0000;
        step();
        aw_we = 1'b0;
        chk("R2 wait edge1", 32'(wr_ok), 32'd0);
        chk("R3 dropped during wait", alarm_word, 32'h0000_1234);
        step();
        chk("R2 rise edge2", 32'(wr_ok), 32'd1);

        // R5 once per minute: only seconds = 30 unignored
        w = {1'b1, 1'b0, 6'h00, 1'b1, 1'b0, 6'h00, 1'b1, 7'h00, 1'b0, 7'h30};
        program_word(w, 1'b1);
        chk("R4 word readback", alarm_word, w);
        for (int i = 0; i < 60; i++)
            apply_vec("R5 minute sweep", bcd(i)[6:0], bcd(i % 7)[6:0], 6'h05, 1'b0, 6'h11, 3'd2);

        // R4 full match with hour and PM
        w = {1'b0, 1'b0, 6'h17, 1'b0, 1'b1, 6'h09, 1'b0, 7'h42, 1'b0, 7'h15};
        program_word(w, 1'b1);
        for (int h = 1; h <= 12; h++)
            for (int p = 0; p < 2; p++)
                apply_vec("R4 hour sweep", 7'h15, 7'h42, bcd(h)[5:0], 1'(p), 6'h17, 3'd3);
        // R6 date sweep
        for (int d = 1; d <= 31; d++)
            apply_vec("R6 date sweep", 7'h15, 7'h42, 6'h09, 1'b1, bcd(d)[5:0], 3'd4);
        apply_vec("R4 minute off", 7'h15, 7'h43, 6'h09, 1'b1, 6'h17, 3'd4);

        // R6 weekday select, weekday 5, seconds 00 unignored
        w = {1'b0, 1'b1, 6'h05, 1'b1, 1'b0, 6'h00, 1'b1, 7'h00, 1'b0, 7'h00};
        program_word(w, 1'b1);
        for (int wd = 1; wd <= 7; wd++)
            for (int d = 3; d <= 27; d += 12)
                apply_vec("R6 weekday sweep", 7'h00, 7'h12, 6'h10, 1'b0, bcd(d)[5:0], 3'(wd));

        // R6 day ignored
        w = {1'b1, 1'b0, 6'h09, 1'b1, 1'b0, 6'h00, 1'b1, 7'h00, 1'b0, 7'h45};
        program_word(w, 1'b1);
        for (int d = 1; d <= 31; d += 5)
            apply_vec("R6 day ignored", 7'h45, 7'h00, 6'h00, 1'b0, bcd(d)[5:0], 3'd6);

        // R7 no tick: matching values without strobe
        cur_sec = 7'h45; cal_tick = 1'b0;
        step(); step();
        chk("R7 no tick", 32'(alarm_flag), 32'd0);
        // R7 enable off
        program_word(w, 1'b0);
        apply_vec("R7 disabled", 7'h45, 7'h00, 6'h00, 1'b0, 6'h01, 3'd1);
        set_cfg(1'b1, 1'b0);

        // R8 and R9: take a match and leave it pending
        cur_sec = 7'h45; cal_tick = 1'b1;
        step();
        cal_tick = 1'b0;
        chk("R8 first evt", 32'(alarm_evt), 32'd1);
        chk("R9 irq masked", 32'(irq), 32'd0);
        cur_sec = 7'h46; cal_tick = 1'b1;
        step(); step();
        cal_tick = 1'b0;
        chk("R8 flag held", 32'(alarm_flag), 32'd1);
        set_cfg(1'b1, 1'b1);
        chk("R9 irq on", 32'(irq), 32'd1);
        cur_sec = 7'h45; cal_tick = 1'b1;
        step();
        cal_tick = 1'b0;
        chk("R8 no second evt", 32'(alarm_evt), 32'd0);
        chk("R8 still set", 32'(alarm_flag), 32'd1);

        // R10 match and clear in the same cycle
        cal_tick = 1'b1; flag_clr = 1'b1;
        step();
        cal_tick = 1'b0; flag_clr = 1'b0;
        chk("R10 flag", 32'(alarm_flag), 32'd1);
        chk("R10 evt",  32'(alarm_evt),  32'd1);
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        chk("R9 irq off after clear", 32'(irq), 32'd0);
        chk("R8 cleared", 32'(alarm_flag), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule